// File: doc/BRIEF.md
# Page Table Walk Translation Unit

This unit resolves a processor virtual address to a physical address after a TLB miss. It reads the page-table entry for that page from memory, checks it, and then either completes the translation or reports a fault. The page table is single-level: each virtual page number selects one byte-wide entry, and the entries start at a base address supplied by the current process.

A request carries a 14-bit virtual address and a read/write flag. The unit captures the request and the table base, and issues exactly one memory read for the entry. It then checks the valid and write-permit bits. When the entry is usable, it first presents the entry on a refill port so the TLB can be loaded, and on the next cycle it presents the physical address. When the entry is not usable, it holds a fault report that carries the virtual address and a cause code until the fault is acknowledged. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset the unit is idle: `req_ready` is 1 and `mem_req_valid`, `refill_valid`, `done_valid` and `fault_valid` are all 0.
- R2: The entry address is `ptbr + VA[13:6]`, modulo 2^12, with one byte per entry. Each walk issues exactly one memory read.
- R3: An entry with bit 7 (valid) equal to 0 gives a fault with `fault_cause` = 2'b01 and `fault_vaddr` equal to the request address. No refill and no physical address are produced.
- R4: A write to a valid entry whose bit 6 (write-permit) is 0 gives a fault with `fault_cause` = 2'b10. A read of a valid entry is always permitted.
- R5: On a permitted access, `refill_valid` pulses for one cycle with `refill_vpn` = VA[13:6] and `refill_pte` = the fetched entry. `done_valid` pulses on the following cycle.
- R6: With `done_valid`, `paddr` = {entry bits 5:0, VA[5:0]}. The page offset passes through unchanged.
- R7: From acceptance until the walk ends, `req_ready` is 0, and any request presented during that time is ignored.
- R8: `fault_valid`, `fault_vaddr` and `fault_cause` hold steady until `fault_ack` is sampled at 1. The unit is then ready again on the next cycle.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| ptbr | input | 12 | Page table base of the current process |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 12 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 8 | Fetched entry |
| refill_valid | output | 1 | One-cycle TLB refill strobe |
| refill_vpn | output | 8 | Virtual page number to refill |
| refill_pte | output | 8 | Entry to load into the TLB |
| done_valid | output | 1 | One-cycle translation-complete strobe |
| paddr | output | 12 | Physical address |
| fault_valid | output | 1 | Fault pending |
| fault_vaddr | output | 14 | Faulting virtual address |
| fault_cause | output | 2 | 01 page fault, 10 protection fault |
| fault_ack | input | 1 | Clears a pending fault |

## Verification
A corrupted captured address shows up as a wrong `mem_req_addr` in the cycle right after acceptance, and again as a wrong `paddr` offset or `fault_vaddr` at the end of the walk. A wrong entry latch or a wrong check outcome appears two to three cycles after the response: the wrong fault cause, a refill where a fault belongs, or a wrong page number. A sequencer that leaves its state too early shows up as `req_ready` rising during a walk or a fault, or as a second memory read, and either is visible within one cycle.

// File: rtl/twk_pkg.sv
// Shared types for the page table walker.
// Assumes one walk in flight; cause codes are seen by software.
package twk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_WAIT, ST_CHECK, ST_REFILL, ST_DONE, ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_PAGE = 2'b01,
        CAUSE_PROT = 2'b10
    } fault_cause_t;
endpackage

// File: rtl/twk_pte_addr.sv
// Forms the entry byte address from the table base and page number.
// Assumes one byte per entry; the sum wraps in the physical space.
module twk_pte_addr #(
    parameter int VPN_W = 8,
    parameter int PA_W  = 12
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  addr
);
    localparam int SUM_W = (PA_W > VPN_W) ? PA_W : VPN_W;

    logic [SUM_W-1:0] sum;

    // Add the zero-extended page number to the base.
    always_comb begin
        sum  = SUM_W'(base) + SUM_W'(vpn);
        addr = sum[PA_W-1:0];
    end
endmodule

// File: rtl/twk_pte_check.sv
// Decodes a fetched entry: bit PPN_W+1 valid, bit PPN_W write-permit,
// low PPN_W bits the physical page number. Purely combinational.
module twk_pte_check #(
    parameter int PPN_W = 6,
    localparam int PTE_W = PPN_W + 2
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    output logic             page_fault,
    output logic             prot_fault,
    output logic [PPN_W-1:0] ppn
);
    // Invalid entry first, then write permission.
    always_comb begin
        page_fault = !pte[PTE_W-1];
        prot_fault = pte[PTE_W-1] && is_write && !pte[PTE_W-2];
        ppn        = pte[PPN_W-1:0];
    end
endmodule

// File: rtl/twk_ctrl.sv
// Walk sequencer: accepts a request, issues the entry read, waits for
// data, then branches to refill+done or to a held fault.
// Assumes memory answers each accepted read with one response.
module twk_ctrl
    import twk_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int OFF_W = 6,
    parameter int PA_W  = 12,
    parameter int PTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [PA_W-1:0]  ptbr,
    output logic [VA_W-1:0]  va_q,
    output logic             wr_q,
    output logic [PA_W-1:0]  base_q,
    output logic [PTE_W-1:0] pte_q,
    input  logic             page_fault,
    input  logic             prot_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             refill_valid,
    output logic             done_valid,
    output logic             fault_valid,
    output logic [1:0]       fault_cause,
    input  logic             fault_ack
);
    walk_state_t  state;
    fault_cause_t cause_q;

    // Next state and captured request, entry and cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            pte_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    base_q <= ptbr;
                    state  <= ST_REQ;
                end
                ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    pte_q <= mem_rsp_data;
                    state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (page_fault) begin
                        cause_q <= CAUSE_PAGE;
                        state   <= ST_FAULT;
                    end else if (prot_fault) begin
                        cause_q <= CAUSE_PROT;
                        state   <= ST_FAULT;
                    end else begin
                        state <= ST_REFILL;
                    end
                end
                ST_REFILL: state <= ST_DONE;
                ST_DONE:   state <= ST_IDLE;
                ST_FAULT:  if (fault_ack) begin
                    cause_q <= CAUSE_NONE;
                    state   <= ST_IDLE;
                end
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Strobes and handshakes decoded from the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_REQ);
        refill_valid  = (state == ST_REFILL);
        done_valid    = (state == ST_DONE);
        fault_valid   = (state == ST_FAULT);
        fault_cause   = cause_q;
    end

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(base_q) && $stable(va_q));

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid && !fault_ack |=> fault_valid && $stable(fault_cause) && $stable(va_q));

    // R5
    refill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(refill_valid));

    // R7
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R3
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_cause == CAUSE_PAGE) || (fault_cause == CAUSE_PROT));

    // R7
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req_valid, refill_valid, done_valid, fault_valid}));
endmodule

// File: rtl/pt_walker.sv
// Page table walker top: wires the sequencer, entry address former and
// entry checker. Assumes the TLB consumes the refill strobe in one cycle.
module pt_walker #(
    parameter int VPN_W = 8,
    parameter int OFF_W = 6,
    parameter int PPN_W = 6,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int PTE_W = PPN_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [PA_W-1:0]  ptbr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             refill_valid,
    output logic [VPN_W-1:0] refill_vpn,
    output logic [PTE_W-1:0] refill_pte,
    output logic             done_valid,
    output logic [PA_W-1:0]  paddr,
    output logic             fault_valid,
    output logic [VA_W-1:0]  fault_vaddr,
    output logic [1:0]       fault_cause,
    input  logic             fault_ack
);
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [PA_W-1:0]  base_q;
    logic [PTE_W-1:0] pte_q;
    logic             page_fault;
    logic             prot_fault;
    logic [PPN_W-1:0] ppn;

    twk_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .ptbr(ptbr),
        .va_q(va_q), .wr_q(wr_q), .base_q(base_q), .pte_q(pte_q),
        .page_fault(page_fault), .prot_fault(prot_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .refill_valid(refill_valid), .done_valid(done_valid),
        .fault_valid(fault_valid), .fault_cause(fault_cause),
        .fault_ack(fault_ack)
    );

    twk_pte_addr #(.VPN_W(VPN_W), .PA_W(PA_W)) u_addr (
        .base(base_q), .vpn(va_q[VA_W-1:OFF_W]), .addr(mem_req_addr)
    );

    twk_pte_check #(.PPN_W(PPN_W)) u_check (
        .pte(pte_q), .is_write(wr_q),
        .page_fault(page_fault), .prot_fault(prot_fault), .ppn(ppn)
    );

    // Result fields taken from the captured request and entry.
    always_comb begin
        refill_vpn  = va_q[VA_W-1:OFF_W];
        refill_pte  = pte_q;
        paddr       = {ppn, va_q[OFF_W-1:0]};
        fault_vaddr = va_q;
    end
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [11:0] ptbr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [11:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        refill_valid;
    logic [7:0]  refill_vpn;
    logic [7:0]  refill_pte;
    logic        done_valid;
    logic [11:0] paddr;
    logic        fault_valid;
    logic [13:0] fault_vaddr;
    logic [1:0]  fault_cause;
    logic        fault_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_pte(refill_pte),
        .done_valid(done_valid), .paddr(paddr),
        .fault_valid(fault_valid), .fault_vaddr(fault_vaddr),
        .fault_cause(fault_cause), .fault_ack(fault_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // kind: 0 = permitted, 1 = page fault, 2 = protection fault
    task automatic walk(input logic [13:0] va, input logic wr,
                        input logic [11:0] base, input logic [7:0] pte,
                        input int stall, input int kind, input int ack_wait);
        logic [11:0] exp_addr;
        logic [11:0] a0;
        int refill_c = -1;
        int done_c = -1;
        int fault_c = -1;
        int extra = 0;
        int n = 0;
        exp_addr = base + {4'b0, va[13:6]};
        @(negedge clk);
        ptbr = base; req_vaddr = va; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        // keep a different request pending while busy: must be ignored
        req_vaddr = va ^ 14'h2AAA; req_write = ~wr; ptbr = base ^ 12'hFFF;
        check(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
        while (!mem_req_valid && n < 10) begin @(negedge clk); n++; end
        check(mem_req_valid && mem_req_addr == exp_addr, "R2", "entry address",
              mem_req_addr, exp_addr);
        for (int s = 0; s < stall; s++) begin
            a0 = mem_req_addr;
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == a0, "R9", "held request",
                  mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (mem_req_valid) extra++;
            if (refill_valid) begin
                refill_c = c;
                check(refill_vpn == va[13:6] && refill_pte == pte, "R5",
                      "refill contents", {refill_vpn, refill_pte}, {va[13:6], pte});
            end
            if (done_valid) begin
                done_c = c;
                check(paddr == {pte[5:0], va[5:0]}, "R6", "physical address",
                      paddr, {pte[5:0], va[5:0]});
                req_valid = 1'b0;
                break;
            end
            if (fault_valid) begin
                fault_c = c;
                req_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
        check(extra == 0, "R2", "extra memory reads", extra, 0);
        if (kind == 0) begin
            check(fault_c < 0 && done_c >= 0 && refill_c == done_c - 1, "R5",
                  "refill one cycle before done", refill_c, done_c - 1);
            @(negedge clk);
            check(req_ready && !done_valid && !refill_valid, "R7",
                  "idle after done", req_ready, 1);
        end else begin
            check(fault_c >= 0 && refill_c < 0 && done_c < 0,
                  kind == 1 ? "R3" : "R4", "fault without refill", fault_c, 0);
            check(fault_cause == (kind == 1 ? 2'b01 : 2'b10),
                  kind == 1 ? "R3" : "R4", "cause", fault_cause, kind);
            check(fault_vaddr == va, "R3", "fault address", fault_vaddr, va);
            for (int w = 0; w < ack_wait; w++) begin
                @(negedge clk);
                check(fault_valid && fault_vaddr == va && !req_ready, "R8",
                      "fault held", fault_valid, 1);
            end
            fault_ack = 1'b1;
            @(negedge clk);
            fault_ack = 1'b0;
            check(!fault_valid && req_ready, "R8", "ready after ack", req_ready, 1);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(req_ready && !mem_req_valid && !refill_valid && !done_valid && !fault_valid,
              "R1", "reset state",
              {req_ready, mem_req_valid, refill_valid, done_valid, fault_valid}, 5'b10000);
    endtask

    task automatic t_read_hit;      walk(14'h03D4, 1'b0, 12'h100, 8'h8D, 0, 0, 0); endtask
    task automatic t_write_ok;      walk(14'h1A7F, 1'b1, 12'h200, 8'hC5, 2, 0, 0); endtask
    task automatic t_read_ro;       walk(14'h0041, 1'b0, 12'h010, 8'h80, 1, 0, 0); endtask // R4 read allowed
    task automatic t_write_ro;      walk(14'h2B3C, 1'b1, 12'h300, 8'hAA & 8'hBF, 0, 2, 3); endtask
    task automatic t_page_read;     walk(14'h3FC0, 1'b0, 12'h040, 8'h7F, 3, 1, 1); endtask
    task automatic t_page_write;    walk(14'h0815, 1'b1, 12'h080, 8'h40, 0, 1, 5); endtask
    task automatic t_wrap;          walk(14'h0823, 1'b0, 12'hFF0, 8'hBF, 0, 0, 0); endtask // R2 wrap

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cycles, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_hit();
        t_write_ok();
        t_read_ro();
        t_write_ro();
        t_page_read();
        t_page_write();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule